// File: doc/BRIEF.md
# Wavefront Sub-Cycle Issue Sequencer

This block issues instructions to a 16-lane SIMD datapath. Each wavefront has 64 threads. One instruction for a wavefront is replayed on four back-to-back cycles, and each cycle covers one quarter of the threads. The quarters always go in ascending order. Lane L carries thread L in the first pass, L+16 in the second, L+32 in the third and L+48 in the last. For each pass the block drives the following outputs:

- a lane-enable vector taken from the thread mask;
- the pass index;
- a thread ID for every lane;
- a register-file row address that includes the wavefront number.

Up to 16 wavefronts may be resident. Each one raises its own bit in `wf_req` when it has an instruction waiting. A round-robin arbiter picks one of them, and the choice appears on `grant_wf`. The upstream side multiplexes that wavefront's opcode, register index and 64-bit mask onto `in_op`, `in_reg` and `in_mask` in the same cycle.

An instruction is taken on a clock edge when `in_ready` is high and at least one `wf_req` bit is set. The block applies back-pressure by holding `in_ready` low during the first three passes. A new instruction can therefore only be taken at the edge that closes the fourth pass, or while the block is idle. There is no buffering at the input. A requester keeps its `wf_req` bit high until it is granted, and the block reads the data inputs only at the edge where it takes an instruction.

Top module: `wfs_issue_seq`

## Requirements
- R1: After an instruction is taken, `iss_valid` is high for exactly four consecutive cycles. Over those cycles `iss_sub` reads 0, 1, 2 and 3, one value per cycle, starting the cycle after the taking edge.
- R2: During a pass, the 6-bit field `lane_tid[6*L+5:6*L]` equals `iss_sub*16 + L` for every lane L.
- R3: During a pass, `lane_en[L]` equals bit `iss_sub*16 + L` of the captured mask. A pass whose 16 mask bits are all zero still takes its cycle, and all its lane enables are low.
- R4: `in_ready` is low during passes 0, 1 and 2. It is high during pass 3 and while idle. With a request waiting at pass 3, the next instruction's pass 0 follows with no gap.
- R5: `done` is high exactly during pass 3, and `done_wf` then equals `iss_wf`.
- R6: `rf_addr` is `{iss_wf, captured register index, iss_sub}`, with the wavefront number in bits 9:6, the register index in bits 5:2 and the pass index in bits 1:0.
- R7: `grant_wf` is the first set `wf_req` bit found by searching upward, with wrap-around, from the wavefront after the last one issued. After reset the search starts at wavefront 0. The granted wavefront becomes `iss_wf` in pass 0.
- R8: When no instruction is in flight, `iss_valid`, `done` and every `lane_en` bit are low.
- R9: While `rst` is high, the following hold: `iss_valid` is 0, `lane_en` is 0, `done` is 0 and `in_ready` is 1.
- R10: Changes on `in_op`, `in_reg` and `in_mask` after the taking edge have no effect on `iss_op`, `rf_addr` or `lane_en` for the rest of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wf_req | input | 16 | One bit per wavefront with an instruction waiting |
| in_ready | output | 1 | High when an instruction can be taken this cycle |
| grant_wf | output | 4 | Wavefront picked by the arbiter (meaningful when `wf_req` is nonzero) |
| in_op | input | 8 | Opcode for the granted wavefront |
| in_reg | input | 4 | Register index for the granted wavefront |
| in_mask | input | 64 | Active-thread mask for the granted wavefront |
| iss_valid | output | 1 | A pass is being issued this cycle |
| iss_sub | output | 2 | Pass (quarter) index |
| iss_wf | output | 4 | Wavefront of the instruction in flight |
| iss_op | output | 8 | Opcode of the instruction in flight |
| lane_en | output | 16 | Per-lane enable for this pass |
| lane_tid | output | 96 | Six-bit thread ID per lane, lane 0 in the low bits |
| rf_addr | output | 10 | Register-file row: wavefront, register, pass |
| done | output | 1 | Fourth pass of an instruction is issuing |
| done_wf | output | 4 | Wavefront whose instruction completes |

## Verification
The completion of one instruction and the taking of the next can fall in the same cycle. During pass 3, `done` is high and `in_ready` is high, so a waiting request is granted at the same edge. This is provoked by keeping several `wf_req` bits set over long stretches, which forces back-to-back issue. It is judged by checking three things: `done` for the old wavefront appears in the same cycle as a grant for the next one, pass 0 of the new wavefront appears in the very next cycle, and the round-robin order stays correct through the hand-over.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int DEF_LANES = 16;
  localparam int DEF_SUBS  = 4;
  localparam int DEF_NWF   = 16;
  localparam int DEF_OP_W  = 8;
  localparam int DEF_REG_W = 4;
endpackage

// File: rtl/wfs_rr_arbiter.sv
module wfs_rr_arbiter #(
  parameter int NWF  = wfs_pkg::DEF_NWF,
  parameter int WF_W = $clog2(NWF)
) (
  input  logic [NWF-1:0]  req,
  input  logic [WF_W-1:0] last,
  output logic [WF_W-1:0] grant,
  output logic            any
);
  // search upward from the slot after the last winner, wrapping around
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 1; i <= NWF; i++) begin
      int idx;
      idx = (int'(last) + i) % NWF;
      if (!any && req[idx]) begin
        grant = WF_W'(idx);
        any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wfs_pass_ctr.sv
module wfs_pass_ctr #(
  parameter int SUBS  = wfs_pkg::DEF_SUBS,
  parameter int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic             busy,
  output logic [SUB_W-1:0] sub,
  output logic             last_pass
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

  assign last_pass = busy && (sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sub  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sub  <= '0;
    end else if (busy) begin
      if (sub == SUB_LAST) begin
        busy <= 1'b0;
        sub  <= '0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wfs_lane_map.sv
module wfs_lane_map #(
  parameter int LANES = wfs_pkg::DEF_LANES,
  parameter int SUBS  = wfs_pkg::DEF_SUBS,
  parameter int WAVE  = LANES * SUBS,
  parameter int SUB_W = $clog2(SUBS),
  parameter int TID_W = $clog2(WAVE)
) (
  input  logic                   valid,
  input  logic [SUB_W-1:0]       sub,
  input  logic [WAVE-1:0]        mask,
  output logic [LANES-1:0]       en,
  output logic [LANES*TID_W-1:0] tid
);
  // fixed mapping: lane l carries thread sub*LANES + l
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign en[l] = valid & mask[int'(sub) * LANES + l];
    assign tid[l*TID_W +: TID_W] = TID_W'(int'(sub) * LANES + l);
  end
endmodule

// File: rtl/wfs_issue_seq.sv
module wfs_issue_seq #(
  parameter int LANES = wfs_pkg::DEF_LANES,
  parameter int SUBS  = wfs_pkg::DEF_SUBS,
  parameter int NWF   = wfs_pkg::DEF_NWF,
  parameter int OP_W  = wfs_pkg::DEF_OP_W,
  parameter int REG_W = wfs_pkg::DEF_REG_W,
  localparam int WAVE  = LANES * SUBS,
  localparam int SUB_W = $clog2(SUBS),
  localparam int WF_W  = $clog2(NWF),
  localparam int TID_W = $clog2(WAVE),
  localparam int RA_W  = WF_W + REG_W + SUB_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWF-1:0]         wf_req,
  output logic                   in_ready,
  output logic [WF_W-1:0]        grant_wf,
  input  logic [OP_W-1:0]        in_op,
  input  logic [REG_W-1:0]       in_reg,
  input  logic [WAVE-1:0]        in_mask,
  output logic                   iss_valid,
  output logic [SUB_W-1:0]       iss_sub,
  output logic [WF_W-1:0]        iss_wf,
  output logic [OP_W-1:0]        iss_op,
  output logic [LANES-1:0]       lane_en,
  output logic [LANES*TID_W-1:0] lane_tid,
  output logic [RA_W-1:0]        rf_addr,
  output logic                   done,
  output logic [WF_W-1:0]        done_wf
);
  logic            busy, last_pass, any_req, take;
  logic [WF_W-1:0] last_wf, cur_wf;
  logic [OP_W-1:0] cur_op;
  logic [REG_W-1:0] cur_reg;
  logic [WAVE-1:0] cur_mask;

  wfs_rr_arbiter #(.NWF(NWF), .WF_W(WF_W)) u_arb (
    .req(wf_req), .last(last_wf), .grant(grant_wf), .any(any_req)
  );

  wfs_pass_ctr #(.SUBS(SUBS), .SUB_W(SUB_W)) u_ctr (
    .clk(clk), .rst(rst), .take(take),
    .busy(busy), .sub(iss_sub), .last_pass(last_pass)
  );

  assign in_ready = !busy || last_pass;
  assign take     = in_ready && any_req;

  // operand capture and arbitration pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      last_wf  <= WF_W'(NWF - 1);
      cur_wf   <= '0;
      cur_op   <= '0;
      cur_reg  <= '0;
      cur_mask <= '0;
    end else if (take) begin
      last_wf  <= grant_wf;
      cur_wf   <= grant_wf;
      cur_op   <= in_op;
      cur_reg  <= in_reg;
      cur_mask <= in_mask;
    end
  end

  wfs_lane_map #(
    .LANES(LANES), .SUBS(SUBS), .WAVE(WAVE), .SUB_W(SUB_W), .TID_W(TID_W)
  ) u_map (
    .valid(busy), .sub(iss_sub), .mask(cur_mask), .en(lane_en), .tid(lane_tid)
  );

  assign iss_valid = busy;
  assign iss_wf    = cur_wf;
  assign iss_op    = cur_op;
  assign rf_addr   = {cur_wf, cur_reg, iss_sub};
  assign done      = last_pass;
  assign done_wf   = cur_wf;
endmodule

// File: rtl/wfs_issue_chk.sv
module wfs_issue_chk #(
  parameter int LANES = 16,
  parameter int SUB_W = 2,
  parameter int NWF   = 16,
  parameter int WF_W  = 4,
  parameter int OP_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NWF-1:0]   wf_req,
  input logic             in_ready,
  input logic [WF_W-1:0]  grant_wf,
  input logic             iss_valid,
  input logic [SUB_W-1:0] iss_sub,
  input logic [WF_W-1:0]  iss_wf,
  input logic [OP_W-1:0]  iss_op,
  input logic [LANES-1:0] lane_en,
  input logic             done,
  input logic [WF_W-1:0]  done_wf
);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  // R1
  sub_step_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_sub != SUB_LAST) |=> (iss_valid && iss_sub == $past(iss_sub) + 1'b1));

  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_sub != SUB_LAST) |-> !in_ready);

  // R5
  done_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (iss_valid && iss_sub == SUB_LAST && done_wf == iss_wf));

  // R8
  lane_off_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> (lane_en == '0 && !done));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_sub != SUB_LAST) |=> ($stable(iss_wf) && $stable(iss_op)));

  // R7
  grant_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && wf_req != '0) |=> (iss_valid && iss_sub == '0 && iss_wf == $past(grant_wf)));
endmodule

bind wfs_issue_seq wfs_issue_chk #(
  .LANES(LANES), .SUB_W(SUB_W), .NWF(NWF), .WF_W(WF_W), .OP_W(OP_W)
) u_chk (
  .clk(clk), .rst(rst), .wf_req(wf_req), .in_ready(in_ready), .grant_wf(grant_wf),
  .iss_valid(iss_valid), .iss_sub(iss_sub), .iss_wf(iss_wf), .iss_op(iss_op),
  .lane_en(lane_en), .done(done), .done_wf(done_wf)
);

// File: tb/tb_wfs_issue_seq.sv
`timescale 1ns/1ps
module tb_wfs_issue_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] wf_req;
  logic        in_ready;
  logic [3:0]  grant_wf;
  logic [7:0]  in_op;
  logic [3:0]  in_reg;
  logic [63:0] in_mask;
  logic        iss_valid;
  logic [1:0]  iss_sub;
  logic [3:0]  iss_wf;
  logic [7:0]  iss_op;
  logic [15:0] lane_en;
  logic [95:0] lane_tid;
  logic [9:0]  rf_addr;
  logic        done;
  logic [3:0]  done_wf;

  always #2.5 clk = ~clk;

  wfs_issue_seq dut (
    .clk(clk), .rst(rst), .wf_req(wf_req), .in_ready(in_ready), .grant_wf(grant_wf),
    .in_op(in_op), .in_reg(in_reg), .in_mask(in_mask), .iss_valid(iss_valid),
    .iss_sub(iss_sub), .iss_wf(iss_wf), .iss_op(iss_op), .lane_en(lane_en),
    .lane_tid(lane_tid), .rf_addr(rf_addr), .done(done), .done_wf(done_wf)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  bit          m_busy;
  int          m_sub;
  logic [3:0]  m_wf, m_last;
  logic [7:0]  m_op;
  logic [3:0]  m_reg;
  logic [63:0] m_mask;

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] rr_pick(logic [3:0] last, logic [15:0] req);
    for (int i = 1; i <= 16; i++) begin
      int idx;
      idx = (int'(last) + i) % 16;
      if (req[idx]) return 4'(idx);
    end
    return 4'd0;
  endfunction

  function automatic logic [95:0] tid_vec(int sub);
    logic [95:0] v;
    for (int l = 0; l < 16; l++) v[l*6 +: 6] = 6'(sub * 16 + l);
    return v;
  endfunction

  task automatic check_outputs();
    check("R1 iss_valid", 96'(iss_valid), 96'(m_busy));
    if (m_busy) begin
      check("R1 iss_sub", 96'(iss_sub), 96'(m_sub));
      check("R10 iss_wf", 96'(iss_wf), 96'(m_wf));
      check("R10 iss_op", 96'(iss_op), 96'(m_op));
      check("R3 lane_en", 96'(lane_en), 96'(m_mask[m_sub*16 +: 16]));
      check("R2 lane_tid", lane_tid, tid_vec(m_sub));
      check("R6 rf_addr", 96'(rf_addr), 96'({m_wf, m_reg, 2'(m_sub)}));
      check("R5 done", 96'(done), 96'(m_sub == 3));
      if (m_sub == 3) check("R5 done_wf", 96'(done_wf), 96'(m_wf));
    end else begin
      check("R8 lane_en idle", 96'(lane_en), 96'd0);
      check("R8 done idle", 96'(done), 96'd0);
    end
  endtask

  // one cycle: check at negedge, drive, check handshake, advance model
  task automatic step(logic [15:0] req, logic [7:0] op, logic [3:0] rg, logic [63:0] mask);
    bit rdy, acc;
    @(negedge clk);
    check_outputs();
    wf_req = req; in_op = op; in_reg = rg; in_mask = mask;
    #1;
    rdy = !m_busy || (m_sub == 3);
    check("R4 in_ready", 96'(in_ready), 96'(rdy));
    if (req != 0) check("R7 grant_wf", 96'(grant_wf), 96'(rr_pick(m_last, req)));
    acc = rdy && (req != 0);
    if (acc) begin
      m_wf = rr_pick(m_last, req); m_last = m_wf;
      m_op = op; m_reg = rg; m_mask = mask;
      m_busy = 1; m_sub = 0;
    end else if (m_busy) begin
      if (m_sub == 3) m_busy = 0; else m_sub++;
    end
  endtask

  function automatic logic [63:0] rand_mask();
    logic [63:0] m;
    m = {$urandom, $urandom};
    for (int q = 0; q < 4; q++) if ($urandom_range(3) == 0) m[q*16 +: 16] = 16'h0;
    return m;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; wf_req = 0; in_op = 0; in_reg = 0; in_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 iss_valid", 96'(iss_valid), 96'd0);
    check("R9 lane_en", 96'(lane_en), 96'd0);
    check("R9 done", 96'(done), 96'd0);
    check("R9 in_ready", 96'(in_ready), 96'd1);
    rst = 0;
    m_busy = 0; m_sub = 0; m_last = 4'd15; m_wf = 0; m_op = 0; m_reg = 0; m_mask = 0;

    // R7 after reset the search starts at wavefront 0
    step(16'hFFFF, 8'h11, 4'h3, 64'hFFFF_FFFF_FFFF_FFFF);
    // R10 inputs wiggle while in flight; single requester back-to-back (R4)
    for (int c = 0; c < 8; c++) step(16'h0020, 8'($urandom), 4'($urandom), {$urandom, $urandom});
    // R3 empty quarter still occupies its cycle
    for (int c = 0; c < 8; c++) step(16'h0100, 8'hA5, 4'h7, 64'hFFFF_0000_00FF_8001);
    // R8 no requests -> idle
    for (int c = 0; c < 6; c++) step(16'h0000, 8'h0, 4'h0, 64'h0);
    // R7 all requesting: full rotation with wrap
    for (int c = 0; c < 70; c++) step(16'hFFFF, 8'(c), 4'(c), rand_mask());
    // R1..R10 constrained random mix
    for (int c = 0; c < 4000; c++) begin
      logic [15:0] r;
      case ($urandom_range(3))
        0: r = 16'h0;
        1: r = 16'(1 << $urandom_range(15));
        default: r = 16'($urandom) & 16'($urandom);
      endcase
      step(r, 8'($urandom), 4'($urandom), rand_mask());
    end
    step(16'h0, 8'h0, 4'h0, 64'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule